// File: doc/BRIEF.md
# Programmable Counter Flag Generator

This block is a single channel of an up/down position counter that raises one interrupt flag line. The counter steps on count-up and count-down strobes that have already been decoded from the encoder signals. A small register write port loads the count, the preset and a control word. The control word enables counting, enables reloading the preset on an index edge, and selects the condition that drives the flag. That condition is one of four: counter carry (overflow), a count step that lands on the preset value, carry or borrow, or a rising edge on the index input.

The count is `LD_W+1` bits wide. Its lower `LD_W` bits are the loadable value. The top bit toggles on every wrap of the lower part, and every load clears it. The flag output is a registered pulse one clock wide, so an interrupt controller can latch it directly. All inputs are taken to be synchronous to `clk`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `pos_cnt_flag`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, count_o is zero and flag_o is low. After reset the preset is zero and the control word is zero: counting is disabled, index reload is off, and the flag function is carry.
- R2: With counting enabled, a cycle with only up_i high adds one to the count. A cycle with only dn_i high subtracts one. A cycle with both strobes high, or neither, leaves the count unchanged.
- R3: With the enable bit at 0, count strobes change neither count_o nor flag_o.
- R4: wr_sel_i selects the target of a write: 0 loads the count, 1 loads the preset, 2 loads the control word, and 3 is ignored. A count write sets count_o to {0, wr_data_i}. Control word fields: bit 0 is the count enable, bit 1 is the index-reload enable, and bits 4:3 are the flag function. A control word or preset write takes effect from the next cycle.
- R5: A carry is an up step from all-ones in the lower LD_W bits, which wraps them to zero. A borrow is a down step from zero, which wraps them to all-ones. Either one toggles count bit LD_W.
- R6: Flag function 0 (carry): flag_o pulses in the cycle after every carry and after nothing else.
- R7: Flag function 1 (compare): flag_o pulses after every count step whose new lower value equals the preset. Loads never raise it.
- R8: Flag function 2 (carry-or-borrow): flag_o pulses after every carry and after every borrow.
- R9: Flag function 3 (index): flag_o pulses after each rising edge of idx_i, whatever the count enable is.
- R10: With index reload enabled, a rising edge of idx_i loads {0, preset} into the count. This reload takes priority over a count step in the same cycle.
- R11: flag_o is high for one cycle per event, even when idx_i stays high for many cycles.
- R12: A count write takes priority over an index reload and over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Count-up strobe |
| dn_i | input | 1 | Count-down strobe |
| idx_i | input | 1 | Index input, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 preset, 2 control, 3 none |
| wr_data_i | input | LD_W | Write data |
| count_o | output | LD_W+1 | Count value, wrap-toggle bit on top |
| flag_o | output | 1 | One-cycle flag event |

## Verification
The assertions assume that idx_i, the strobes and the write port are synchronous to clk. They also assume idx_i is low when reset is released, so that no index edge appears at the first active cycle. The bench drives every input on the falling edge and holds idx_i low through reset. It sweeps a narrow 8-bit configuration through full wraps in both directions and through a long pseudo-random up/down sequence. A cycle-by-cycle arithmetic model supplies the expected count and flag.

// File: rtl/pos_cnt_flag_pkg.sv
package pos_cnt_flag_pkg;

  // flag source selection, code values are part of the control word
  typedef enum logic [1:0] {
    FN_CARRY = 2'd0,
    FN_MATCH = 2'd1,
    FN_WRAP  = 2'd2,
    FN_INDEX = 2'd3
  } flag_fn_e;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PRESET = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  typedef struct packed {
    flag_fn_e fn;
    logic     pl;
    logic     en;
  } ctl_t;

  // control word bit positions
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_PL_BIT = 1;
  localparam int CTL_FN_LSB = 3;

endpackage

// File: rtl/pos_cnt_flag_cfg.sv
module pos_cnt_flag_cfg
  import pos_cnt_flag_pkg::*;
#(
  parameter int LD_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [LD_W-1:0] wr_data_i,
  output logic [LD_W-1:0] preset_o,
  output ctl_t            ctl_o
);

  logic [LD_W-1:0] preset_q, preset_d;
  ctl_t            ctl_q, ctl_d;
  logic            preset_ce, ctl_ce;

  always_comb begin
    preset_ce = wr_en_i && (wr_sel_i == SEL_PRESET);
    ctl_ce    = wr_en_i && (wr_sel_i == SEL_CTRL);
    preset_d  = wr_data_i;
    ctl_d.en  = wr_data_i[CTL_EN_BIT];
    ctl_d.pl  = wr_data_i[CTL_PL_BIT];
    ctl_d.fn  = flag_fn_e'(wr_data_i[CTL_FN_LSB+1:CTL_FN_LSB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      ctl_q    <= '{fn: FN_CARRY, pl: 1'b0, en: 1'b0};
    end else begin
      if (preset_ce) preset_q <= preset_d;
      if (ctl_ce)    ctl_q    <= ctl_d;
    end
  end

  assign preset_o = preset_q;
  assign ctl_o    = ctl_q;

endmodule

// File: rtl/pos_cnt_flag_core.sv
module pos_cnt_flag_core #(
  parameter int LD_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_i,
  input  logic            dn_i,
  input  logic            en_i,
  input  logic            wr_cnt_i,
  input  logic [LD_W-1:0] wr_data_i,
  input  logic            ld_pre_i,
  input  logic [LD_W-1:0] preset_i,
  output logic [LD_W:0]   count_o,
  output logic            carry_o,
  output logic            borrow_o,
  output logic            match_o
);

  localparam logic [LD_W-1:0] LO_MAX = {LD_W{1'b1}};

  logic [LD_W:0]   cnt_q, cnt_d;
  logic [LD_W-1:0] lo, lo_step;
  logic            up_ok, dn_ok, move, cnt_ce, wrap;

  always_comb begin
    lo      = cnt_q[LD_W-1:0];
    up_ok   = en_i && up_i && !dn_i;
    dn_ok   = en_i && dn_i && !up_i;
    // loads win over a step in the same cycle
    move    = (up_ok || dn_ok) && !wr_cnt_i && !ld_pre_i;
    lo_step = up_ok ? lo + 1'b1 : lo - 1'b1;
    carry_o  = move && up_ok && (lo == LO_MAX);
    borrow_o = move && dn_ok && (lo == '0);
    wrap     = carry_o || borrow_o;
    match_o  = move && (lo_step == preset_i);
    cnt_ce   = wr_cnt_i || ld_pre_i || move;
    if (wr_cnt_i)      cnt_d = {1'b0, wr_data_i};
    else if (ld_pre_i) cnt_d = {1'b0, preset_i};
    else               cnt_d = {cnt_q[LD_W] ^ wrap, lo_step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pos_cnt_flag_evt.sv
module pos_cnt_flag_evt
  import pos_cnt_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  flag_fn_e fn_i,
  input  logic     carry_i,
  input  logic     borrow_i,
  input  logic     match_i,
  input  logic     idx_i,
  output logic     idx_rise_o,
  output logic     flag_o
);

  logic idx_q, flag_q, flag_d;

  always_comb begin
    idx_rise_o = idx_i && !idx_q;
    unique case (fn_i)
      FN_CARRY: flag_d = carry_i;
      FN_MATCH: flag_d = match_i;
      FN_WRAP:  flag_d = carry_i || borrow_i;
      FN_INDEX: flag_d = idx_rise_o;
      default:  flag_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      idx_q  <= idx_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pos_cnt_flag.sv
module pos_cnt_flag
  import pos_cnt_flag_pkg::*;
#(
  parameter int LD_W   = 24,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_i,
  input  logic            dn_i,
  input  logic            idx_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [LD_W-1:0] wr_data_i,
  output logic [LD_W:0]   count_o,
  output logic            flag_o
);

  logic [SYNC_N-1:0] rs_q;
  logic              rst_sync_n;
  logic [LD_W-1:0]   preset;
  ctl_t              ctl;
  logic              wr_cnt, ld_pre, idx_rise;
  logic              carry, borrow, match;

  // reset: asserted at once, released after SYNC_N edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_N-1];

  always_comb begin
    wr_cnt = wr_en_i && (wr_sel_i == SEL_COUNT);
    ld_pre = idx_rise && ctl.pl && !wr_cnt;
  end

  pos_cnt_flag_cfg #(.LD_W(LD_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .preset_o  (preset),
    .ctl_o     (ctl)
  );

  pos_cnt_flag_core #(.LD_W(LD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .en_i      (ctl.en),
    .wr_cnt_i  (wr_cnt),
    .wr_data_i (wr_data_i),
    .ld_pre_i  (ld_pre),
    .preset_i  (preset),
    .count_o   (count_o),
    .carry_o   (carry),
    .borrow_o  (borrow),
    .match_o   (match)
  );

  pos_cnt_flag_evt u_evt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fn_i       (ctl.fn),
    .carry_i    (carry),
    .borrow_i   (borrow),
    .match_i    (match),
    .idx_i      (idx_i),
    .idx_rise_o (idx_rise),
    .flag_o     (flag_o)
  );

endmodule

// File: rtl/pos_cnt_flag_chk.sv
module pos_cnt_flag_chk
  import pos_cnt_flag_pkg::*;
#(
  parameter int LD_W = 24
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic [LD_W:0]   count_o,
  input logic            flag_o,
  input logic            wr_cnt,
  input logic [LD_W-1:0] wr_data_i,
  input logic            ld_pre,
  input logic [LD_W-1:0] preset,
  input logic            ctl_en,
  input flag_fn_e        ctl_fn,
  input logic            idx_rise
);

  // R3
  strobes_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_en && !wr_cnt && !ld_pre) |=> $stable(count_o));

  // R4
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_cnt |=> (count_o == {1'b0, $past(wr_data_i)}));

  // R10
  index_reload_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_pre |=> (count_o == {1'b0, $past(preset)}));

  // R9
  index_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_fn == FN_INDEX && idx_rise) |=> flag_o);

  // R6
  carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_fn == FN_CARRY && !ctl_en) |=> !flag_o);

  // R11
  index_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_fn == FN_INDEX && !idx_rise) |=> !flag_o);

endmodule

bind pos_cnt_flag pos_cnt_flag_chk #(.LD_W(LD_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .count_o    (count_o),
  .flag_o     (flag_o),
  .wr_cnt     (wr_cnt),
  .wr_data_i  (wr_data_i),
  .ld_pre     (ld_pre),
  .preset     (preset),
  .ctl_en     (ctl.en),
  .ctl_fn     (ctl.fn),
  .idx_rise   (idx_rise)
);

// File: tb/pos_cnt_flag_test.sv
module pos_cnt_flag_test;

  localparam int LD_W = 8;
  localparam logic [LD_W-1:0] MAXV = {LD_W{1'b1}};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            up, dn, idx, wr;
  logic [1:0]      sel;
  logic [LD_W-1:0] data;
  logic [LD_W:0]   count_o;
  logic            flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [LD_W:0]   m_cnt;
  logic [LD_W-1:0] m_pre;
  logic            m_en, m_pl, m_ip;
  logic [1:0]      m_fn;
  logic [15:0]     lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  pos_cnt_flag #(.LD_W(LD_W)) uut (
    .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn), .idx_i(idx),
    .wr_en_i(wr), .wr_sel_i(sel), .wr_data_i(data),
    .count_o(count_o), .flag_o(flag_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic cyc(input string tag, input logic u_i, input logic d_i,
                     input logic x_i, input logic w_i, input logic [1:0] s_i,
                     input logic [LD_W-1:0] v_i);
    logic wc, ir, ld, u, d, mv, cy, bw, mt, ef;
    logic [LD_W-1:0] lo, nlo;
    up = u_i; dn = d_i; idx = x_i; wr = w_i; sel = s_i; data = v_i;
    wc = w_i && s_i == 2'd0;
    ir = x_i && !m_ip;
    ld = ir && m_pl && !wc;
    u  = m_en && u_i && !d_i;
    d  = m_en && d_i && !u_i;
    mv = (u || d) && !wc && !ld;
    lo = m_cnt[LD_W-1:0];
    nlo = u ? lo + 1'b1 : lo - 1'b1;
    cy = mv && u && lo == MAXV;
    bw = mv && d && lo == '0;
    mt = mv && nlo == m_pre;
    case (m_fn)
      2'd0: ef = cy;
      2'd1: ef = mt;
      2'd2: ef = cy || bw;
      default: ef = ir;
    endcase
    if (wc)      m_cnt = {1'b0, v_i};
    else if (ld) m_cnt = {1'b0, m_pre};
    else if (mv) m_cnt = {m_cnt[LD_W] ^ (cy || bw), nlo};
    if (w_i && s_i == 2'd1) m_pre = v_i;
    if (w_i && s_i == 2'd2) begin
      m_en = v_i[0]; m_pl = v_i[1]; m_fn = v_i[4:3];
    end
    m_ip = x_i;
    @(negedge clk);
    chk(tag, "count", 32'(count_o), 32'(m_cnt));
    chk(tag, "flag", 32'(flag_o), 32'(ef));
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic wreg(input string tag, input logic [1:0] s, input logic [LD_W-1:0] v);
    cyc(tag, 1'b0, 1'b0, 1'b0, 1'b1, s, v);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; up = 0; dn = 0; idx = 0; wr = 0; sel = 0; data = '0;
    m_cnt = '0; m_pre = '0; m_en = 0; m_pl = 0; m_ip = 0; m_fn = 2'd0;
    repeat (3) @(negedge clk);
    // R1: outputs held clear during reset
    chk("R1", "count in reset", 32'(count_o), 0);
    chk("R1", "flag in reset", 32'(flag_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "count after reset", 32'(count_o), 0);
    chk("R1", "flag after reset", 32'(flag_o), 0);

    // R3: counting disabled by default; strobes and a borrow attempt ignored
    for (int i = 0; i < 10; i++) cyc("R3", i[0], !i[0], 1'b0, 1'b0, 2'd0, '0);

    // R4: enable, carry function; count load; ignored select 3
    wreg("R4", 2'd2, 8'h01);
    wreg("R4", 2'd0, 8'hF0);
    wreg("R4", 2'd3, 8'h5A);
    idle("R4", 2);

    // R6 / R5: full up sweep with carry flag
    for (int i = 0; i < 300; i++) cyc("R6", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0);
    // R5: down sweep through borrow, carry mode stays quiet
    for (int i = 0; i < 300; i++) cyc("R5", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, '0);
    // R4: a count load clears the wrap bit
    wreg("R4", 2'd0, MAXV);
    cyc("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0);
    wreg("R4", 2'd0, 8'h10);

    // R2: both / neither strobes
    for (int i = 0; i < 16; i++) cyc("R2", i[1], i[1] ^ i[0], 1'b0, 1'b0, 2'd0, '0);

    // R8: carry-or-borrow function
    wreg("R8", 2'd2, 8'h11);
    for (int i = 0; i < 300; i++) cyc("R8", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, '0);
    for (int i = 0; i < 300; i++) cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0);

    // R7: compare function under pseudo-random stepping
    wreg("R7", 2'd2, 8'h09);
    wreg("R7", 2'd1, 8'h35);
    wreg("R7", 2'd0, 8'h30);
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i == 1000) wreg("R7", 2'd1, 8'h00);
      else if (i == 2000) wreg("R7", 2'd1, MAXV);
      else if (i % 97 == 0) wreg("R7", 2'd0, lfsr[15:8]);
      else cyc("R7", lfsr[0], lfsr[1] & lfsr[2], 1'b0, 1'b0, 2'd0, '0);
    end
    // R7: loading the preset value itself raises nothing
    wreg("R7", 2'd0, MAXV);

    // R9: index function, counting disabled, pulses of several widths
    wreg("R9", 2'd2, 8'h18);
    for (int w = 1; w <= 4; w++) begin
      for (int i = 0; i < w; i++) cyc("R9", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0);
      idle("R9", w);
    end
    // R11: index held high for many cycles yields one pulse
    for (int i = 0; i < 20; i++) cyc("R11", 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, '0);
    idle("R11", 2);

    // R10: reload on index edge, beats a step in the same cycle
    wreg("R10", 2'd2, 8'h1B);
    wreg("R10", 2'd1, 8'h77);
    for (int i = 0; i < 5; i++) cyc("R10", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0);
    cyc("R10", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0);
    cyc("R10", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0);
    cyc("R10", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, '0);
    cyc("R10", 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, '0);

    // R12: count write beats index reload and step
    idle("R12", 1);
    cyc("R12", 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 8'hA5);
    cyc("R12", 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'h3C);
    idle("R12", 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule